// File: doc/BRIEF.md
# Pipelined Burst Static RAM with Byte Lanes

This block is a synthesizable model of a single-clock static RAM with a 32-bit word and a parameterized address width. All address, data and control inputs are taken in on the rising clock edge. An access opens a burst when either of two active-low address strobes is asserted: a processor-side strobe or a controller-side strobe. The external address is loaded on that edge. Later words of the burst come from a 2-bit internal step counter. The counter moves forward only on edges where the active-low advance input is asserted. The burst therefore stays inside an aligned group of four words.

An order-select input picks linear stepping or interleaved stepping for each burst. Writes may cover any subset of the four byte lanes through a byte-write enable and per-lane strobes. An active-low global write overrides the lane controls and writes the whole word. Three chip enables must all be in their active state for a strobe to open an access.

Read data comes out one clock after the access is registered. A data-valid flag stands in for the output enable of a shared data bus.

Top module: `burst_sram`

## Requirements
- R1: A read access registered on edge k places the addressed word on `dout` after edge k+1 with `dout_en` high. `dout_en` is low after every edge whose registered access was not a read.
- R2: A strobe edge with the chip selected loads `addr` as the burst start. If `start_cpu_n` is low on that edge, the access is a read whatever the write controls are. If both strobes are low together, the processor strobe's read rule applies.
- R3: On an edge with no strobe while a burst is open, `adv_n` low moves the step count forward by one (mod 4). `adv_n` high keeps the step count, so the same word is accessed again.
- R4: With `order_sel` = 0 on the start edge, address bits [1:0] equal (start[1:0] + step) mod 4. Bits above bit 1 never change within a burst.
- R5: With `order_sel` = 1 on the start edge, address bits [1:0] equal start[1:0] XOR step. A start of 1 therefore gives 1,0,3,2.
- R6: A write access with `gw_n` low writes all four bytes, whatever `bwe_n` and `bw_n` are.
- R7: With `gw_n` high and `bwe_n` low, the access is a write. Byte lane i (bits 8i+7:8i) is written only when `bw_n[i]` is 0. The other lanes keep their contents.
- R8: A controller-strobe or continuation access with both `gw_n` and `bwe_n` high is a read.
- R9: The chip is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. A strobe edge without selection performs no access and closes the burst. Later edges without a strobe then perform no access.
- R10: After synchronous reset, `dout_en` and `dout` are 0 and no burst is open.
- R11: A strobe on an edge inside an open burst restarts at the new address, even when `adv_n` is low on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Word address loaded on a strobe edge |
| din | input | 32 | Write data |
| start_cpu_n | input | 1 | Processor-side burst strobe, active low |
| start_ctl_n | input | 1 | Controller-side burst strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 linear, 1 interleaved burst order |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 4 | Per-lane write strobes, active low |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| dout | output | 32 | Read data |
| dout_en | output | 1 | Read data valid, drives the bus when high |

## Verification
The bench provokes two cases in which functions coincide on one edge. In the first, a new strobe arrives in the middle of a burst while `adv_n` is also low. In the second, both strobes are asserted together while the global write is active. The bench's behavioural model says the restart beats the advance and the processor read beats the write. The bench judges each case on the following edge from `dout`: the word read back must be the one at the new address, and a word that a wrongly honoured write would have changed must be unchanged.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = 4;
    localparam int LANE_W  = WORD_W / LANES;
    localparam int STEP_W  = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } access_op_e;

    typedef struct packed {
        access_op_e        op;
        logic [LANES-1:0]  lanes;
    } access_ctl_t;

    localparam access_ctl_t CTL_IDLE = '{op: OP_IDLE, lanes: '0};

    function automatic logic [STEP_W-1:0] burst_offset(
        input logic [STEP_W-1:0] start,
        input logic [STEP_W-1:0] step,
        input burst_order_e      ord
    );
        logic [STEP_W-1:0] res;
        if (ord == ORD_LINEAR) res = start + step;
        else                   res = start ^ step;
        return res;
    endfunction

    function automatic logic [LANES-1:0] lane_select(
        input logic             gw_n,
        input logic             bwe_n,
        input logic [LANES-1:0] bw_n
    );
        logic [LANES-1:0] res;
        res = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!gw_n)                res[i] = 1'b1;
            else if (!bwe_n && !bw_n[i]) res[i] = 1'b1;
        end
        return res;
    endfunction

endpackage

// File: rtl/bsr_addr_gen.sv
module bsr_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe_any,
    input  logic          chip_sel,
    input  logic          adv_n,
    input  logic          order_sel,
    input  logic [AW-1:0] addr_in,
    output logic          acc_valid,
    output logic [AW-1:0] acc_addr,
    output logic          burst_live
);

    localparam int HI_W = AW - STEP_W;

    logic [AW-1:0]     base_q,  base_d;
    logic [STEP_W-1:0] step_q,  step_d;
    burst_order_e      ord_q,   ord_d;
    logic              live_q,  live_d;
    logic [STEP_W-1:0] low_bits;

    always_comb begin
        base_d    = base_q;
        step_d    = step_q;
        ord_d     = ord_q;
        live_d    = live_q;
        acc_valid = 1'b0;
        acc_addr  = base_q;
        low_bits  = '0;
        if (strobe_any) begin
            if (chip_sel) begin
                base_d    = addr_in;
                step_d    = '0;
                ord_d     = burst_order_e'(order_sel);
                live_d    = 1'b1;
                acc_valid = 1'b1;
                acc_addr  = addr_in;
            end else begin
                live_d    = 1'b0;
            end
        end else if (live_q) begin
            if (!adv_n) step_d = step_q + 1'b1;
            low_bits  = burst_offset(base_q[STEP_W-1:0], step_d, ord_q);
            acc_addr  = {base_q[AW-1:STEP_W], low_bits};
            acc_valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            step_q <= '0;
            ord_q  <= ORD_LINEAR;
            live_q <= 1'b0;
        end else begin
            base_q <= base_d;
            step_q <= step_d;
            ord_q  <= ord_d;
            live_q <= live_d;
        end
    end

    assign burst_live = live_q;

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = base_q[AW-1:STEP_W];

endmodule

// File: rtl/bsr_write_decode.sv
module bsr_write_decode
    import burst_sram_pkg::*;
(
    input  logic             cpu_start,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output access_ctl_t      ctl
);

    always_comb begin
        ctl = '{op: OP_READ, lanes: '0};
        if (!cpu_start && (!gw_n || !bwe_n)) begin
            ctl.op    = OP_WRITE;
            ctl.lanes = lane_select(gw_n, bwe_n, bw_n);
        end
    end

endmodule

// File: rtl/bsr_array.sv
module bsr_array
    import burst_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  access_ctl_t       req_ctl,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_en
);

    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] rd_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (req_ctl.op == OP_WRITE && req_ctl.lanes[g])
                lane_mem[req_addr] <= req_data[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = lane_mem[req_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_en   <= 1'b0;
            rd_data <= '0;
        end else if (req_ctl.op == OP_READ) begin
            rd_en   <= 1'b1;
            rd_data <= rd_word;
        end else begin
            rd_en   <= 1'b0;
        end
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] din,
    input  logic              start_cpu_n,
    input  logic              start_ctl_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    logic              strobe_any;
    logic              chip_sel;
    logic              acc_valid;
    logic [AW-1:0]     acc_addr;
    logic              burst_live;
    access_ctl_t       dec_ctl;

    access_ctl_t       stg_ctl;
    logic [AW-1:0]     stg_addr;
    logic [WORD_W-1:0] stg_data;

    assign strobe_any = !start_cpu_n || !start_ctl_n;
    assign chip_sel   = !en_a_n && en_b && !en_c_n;

    bsr_addr_gen #(.AW(AW)) u_addr_gen (
        .clk        (clk),
        .rst        (rst),
        .strobe_any (strobe_any),
        .chip_sel   (chip_sel),
        .adv_n      (adv_n),
        .order_sel  (order_sel),
        .addr_in    (addr),
        .acc_valid  (acc_valid),
        .acc_addr   (acc_addr),
        .burst_live (burst_live)
    );

    bsr_write_decode u_wr_dec (
        .cpu_start (!start_cpu_n),
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bw_n      (bw_n),
        .ctl       (dec_ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_ctl  <= CTL_IDLE;
            stg_addr <= '0;
            stg_data <= '0;
        end else begin
            stg_ctl  <= acc_valid ? dec_ctl : CTL_IDLE;
            stg_addr <= acc_addr;
            stg_data <= din;
        end
    end

    bsr_array #(.AW(AW)) u_array (
        .clk      (clk),
        .rst      (rst),
        .req_ctl  (stg_ctl),
        .req_addr (stg_addr),
        .req_data (stg_data),
        .rd_data  (dout),
        .rd_en    (dout_en)
    );

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker
    import burst_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start_cpu_n,
    input logic          start_ctl_n,
    input logic          adv_n,
    input logic          gw_n,
    input logic          en_a_n,
    input logic          en_b,
    input logic          en_c_n,
    input logic          acc_valid,
    input logic          burst_live,
    input access_ctl_t   stg_ctl,
    input logic [AW-1:0] stg_addr,
    input logic          dout_en
);

    logic strobe;
    logic sel;
    assign strobe = !start_cpu_n || !start_ctl_n;
    assign sel    = !en_a_n && en_b && !en_c_n;

    assert_read_valid_R1: assert property (@(posedge clk) disable iff (rst)
        (stg_ctl.op == OP_READ) |=> dout_en);

    assert_no_valid_R1: assert property (@(posedge clk) disable iff (rst)
        (stg_ctl.op != OP_READ) |=> !dout_en);

    assert_cpu_reads_R2: assert property (@(posedge clk) disable iff (rst)
        (!start_cpu_n && sel) |=> (stg_ctl.op == OP_READ));

    assert_hold_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (burst_live && !strobe && adv_n) |=> (stg_addr == $past(stg_addr)));

    assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (burst_live && !strobe) |=>
            (stg_addr[AW-1:STEP_W] == $past(stg_addr[AW-1:STEP_W])));

    assert_global_write_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && start_cpu_n && !gw_n) |=>
            (stg_ctl.op == OP_WRITE && stg_ctl.lanes == 4'hF));

    assert_deselect_R9: assert property (@(posedge clk) disable iff (rst)
        (strobe && !sel) |=> (stg_ctl.op == OP_IDLE));

endmodule

bind burst_sram bsr_checker #(.AW(AW)) u_bsr_checker (
    .clk         (clk),
    .rst         (rst),
    .start_cpu_n (start_cpu_n),
    .start_ctl_n (start_ctl_n),
    .adv_n       (adv_n),
    .gw_n        (gw_n),
    .en_a_n      (en_a_n),
    .en_b        (en_b),
    .en_c_n      (en_c_n),
    .acc_valid   (acc_valid),
    .burst_live  (burst_live),
    .stg_ctl     (stg_ctl),
    .stg_addr    (stg_addr),
    .dout_en     (dout_en)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int DEPTH      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [31:0]   din = '0;
    logic          start_cpu_n = 1'b1;
    logic          start_ctl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic          gw_n = 1'b1;
    logic          bwe_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          en_a_n = 1'b0;
    logic          en_b = 1'b1;
    logic          en_c_n = 1'b0;
    logic [31:0]   dout;
    logic          dout_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sram #(.AW(AW)) i_burst_sram (
        .clk(clk), .rst(rst), .addr(addr), .din(din),
        .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n),
        .adv_n(adv_n), .order_sel(order_sel), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .en_a_n(en_a_n), .en_b(en_b),
        .en_c_n(en_c_n), .dout(dout), .dout_en(dout_en)
    );

    // behavioural reference
    logic [31:0] ref_mem [DEPTH];
    bit          m_live = 0;
    int          m_base = 0, m_step = 0;
    bit          m_ord = 0;
    bit          s_valid = 0, s_write = 0;
    int          s_addr = 0;
    logic [31:0] s_data = '0;
    logic [3:0]  s_mask = '0;
    bit          exp_en = 0;
    logic [31:0] exp_dout = '0;

    task automatic model_edge();
        bit sel, strobe, acc;
        int a, low;
        if (rst) begin
            m_live = 0; s_valid = 0; exp_en = 0; exp_dout = '0;
            return;
        end
        exp_en = s_valid && !s_write;
        if (exp_en) exp_dout = ref_mem[s_addr];
        if (s_valid && s_write)
            for (int b = 0; b < 4; b++)
                if (s_mask[b]) ref_mem[s_addr][b*8 +: 8] = s_data[b*8 +: 8];
        sel    = !en_a_n && en_b && !en_c_n;
        strobe = !start_cpu_n || !start_ctl_n;
        acc = 0; a = 0;
        if (strobe) begin
            if (sel) begin
                m_live = 1; m_base = int'(addr); m_step = 0; m_ord = order_sel;
                acc = 1; a = int'(addr);
            end else m_live = 0;
        end else if (m_live) begin
            if (!adv_n) m_step = (m_step + 1) % 4;
            low = m_ord ? ((m_base % 4) ^ m_step) : ((m_base % 4 + m_step) % 4);
            a = m_base - (m_base % 4) + low;
            acc = 1;
        end
        s_valid = acc;
        s_addr  = a;
        s_data  = din;
        s_write = acc && start_cpu_n && (!gw_n || !bwe_n);
        s_mask  = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
    endtask

    task automatic compare(input string tag);
        checks++;
        if (dout_en !== exp_en) begin
            errors++;
            $display("FAIL %s dout_en actual %b expected %b", tag, dout_en, exp_en);
        end else if (exp_en && dout !== exp_dout) begin
            errors++;
            $display("FAIL %s dout actual %h expected %h", tag, dout, exp_dout);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic expect_word(input string tag, input logic [31:0] exp);
        checks++;
        if (dout_en !== 1'b1 || dout !== exp) begin
            errors++;
            $display("FAIL %s dout actual %h (en %b) expected %h", tag, dout, dout_en, exp);
        end
    endtask

    task automatic idle();
        start_cpu_n = 1; start_ctl_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF;
        en_a_n = 0; en_b = 1; en_c_n = 0;
    endtask

    task automatic start(input bit cpu, input logic [AW-1:0] a, input bit ord);
        idle();
        if (cpu) start_cpu_n = 0; else start_ctl_n = 0;
        addr = a; order_sel = ord;
    endtask

    task automatic cont(input bit adv);
        idle();
        adv_n = !adv;
    endtask

    // single read through the processor strobe, then check the word
    task automatic read_word(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        start(1, a, 0); tick(tag);
        idle();
        start_ctl_n = 1; tick(tag);
        expect_word(tag, exp);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) tick("R10");
        rst = 0;
        checks++;
        if (dout_en !== 1'b0 || dout !== 32'h0) begin
            errors++;
            $display("FAIL R10 reset actual en %b dout %h expected 0 0", dout_en, dout);
        end
        tick("R10");

        // R6/R4: linear write burst from offset 1, global write
        start(0, 8'h11, 0); gw_n = 0; din = 32'hA000_00A0; tick("R6");
        for (int i = 1; i < 4; i++) begin
            cont(1); gw_n = 0; din = 32'hA000_00A0 + i; tick("R4");
        end
        idle(); tick("R4");
        read_word("R4 wrap to group base", 8'h10, 32'hA000_00A3);

        // R5: interleaved read from offset 1 -> 1,0,3,2
        start(1, 8'h11, 1); tick("R5");
        cont(1); tick("R5");
        expect_word("R5 first word", 32'hA000_00A0);
        cont(1); tick("R5");
        expect_word("R5 second word at offset 0", 32'hA000_00A3);
        cont(1); tick("R5");
        expect_word("R5 third word at offset 3", 32'hA000_00A2);
        idle(); tick("R5");
        expect_word("R5 fourth word at offset 2", 32'hA000_00A1);
        tick("R1");

        // R7: partial byte write, lanes 0 and 2
        start(0, 8'h20, 0); gw_n = 0; din = 32'h1122_3344; tick("R6");
        start(0, 8'h20, 0); bwe_n = 0; bw_n = 4'b1010; din = 32'hAABB_CCDD; tick("R7");
        idle(); tick("R7");
        read_word("R7 lanes 0 and 2", 8'h20, 32'h11BB_33DD);

        // R6 override: lane strobes all off, bwe off, gw on
        start(0, 8'h24, 0); gw_n = 0; din = 32'hCAFE_F00D; tick("R6");
        idle(); tick("R6");
        // R8: controller strobe without write enables reads
        start(0, 8'h24, 0); din = 32'h0; tick("R8");
        idle(); tick("R8");
        expect_word("R8 controller read", 32'hCAFE_F00D);

        // R3: hold with advance off, then step
        start(1, 8'h12, 0); tick("R3");
        cont(0); tick("R3");
        cont(0); tick("R3");
        expect_word("R3 hold repeats word", 32'hA000_00A1);
        cont(1); tick("R3");
        expect_word("R3 hold repeats word", 32'hA000_00A1);
        idle(); tick("R3");
        expect_word("R3 step to next word", 32'hA000_00A2);

        // R9: deselect mid-burst
        start(1, 8'h10, 0); tick("R9");
        start(1, 8'h13, 0); en_b = 0; tick("R9");
        cont(1); tick("R9");
        checks++;
        if (dout_en !== 1'b0) begin
            errors++;
            $display("FAIL R9 dout_en actual %b expected 0", dout_en);
        end
        cont(1); tick("R9");
        cont(1); tick("R9");

        // R11: restart wins over advance
        start(0, 8'h30, 0); gw_n = 0; din = 32'h3030_3030; tick("R11");
        start(1, 8'h11, 0); adv_n = 0; tick("R11");
        cont(1); tick("R11");
        expect_word("R11 restart address", 32'hA000_00A0);

        // R2: both strobes with global write -> read, no write
        idle(); start_cpu_n = 0; start_ctl_n = 0; addr = 8'h10; gw_n = 0;
        din = 32'hDEAD_BEEF; tick("R2");
        idle(); tick("R2");
        expect_word("R2 processor read wins", 32'hA000_00A3);
        read_word("R2 word unchanged", 8'h10, 32'hA000_00A3);
        read_word("R1 other burst word", 8'h30, 32'h3030_3030);
        tick("R1");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule